// File: doc/BRIEF.md
# Two-Channel Bus Break Condition Unit

This unit sits beside a processor's bus and watches every bus cycle. Software programs two comparison channels, A and B, through a small write-only register port. Each channel can match on several conditions of the cycle: the logical address under a selectable mask, the address-space ID, whether the cycle is an instruction fetch or a data access, the direction, and the operand size. Channel B can also compare the data bus under a per-bit mask. When the programmed conditions hold, the unit raises a one-cycle break request for the trap logic.

There are two trigger modes. In independent mode a match on either channel raises the request. In sequential mode a match on channel A arms an internal flag, and a later match on channel B raises the request only while that flag is armed. For instruction-fetch breaks, a side output tells the trap logic whether to take the break before or after the fetched instruction executes. Each channel also keeps a sticky match flag, visible on a port, that software clears by writing.

Register indices on `reg_idx`: 0 A address, 1 A ASID, 2 A control, 3 B address, 4 B ASID, 5 B control, 6 B data value, 7 B data mask, 8 mode, 9 status clear. Writes to any other index store nothing. Channel control word fields: [1:0] address mask, [2] ASID ignore, [4:3] cycle kind, [6:5] direction, [8:7] size, [9] after-execution.

Top module: `bus_break_unit`

## Requirements
- R1: The address mask field (control bits [1:0]) selects 0 = all 32 bits compared, 1 = low 10 bits ignored, 2 = low 12 bits ignored, 3 = no address bit compared.
- R2: Control bit [2] set makes the 8-bit ASID always pass; clear, the bus ASID must equal the programmed ASID.
- R3: The cycle kind field (control bits [4:3]) selects 0 = channel never matches, 1 = instruction fetches only, 2 = data accesses only, 3 = both.
- R4: The direction field (control bits [6:5]) selects 1 = reads only, 2 = writes only, 0 or 3 = both.
- R5: The size field (control bits [8:7]) selects 0 = byte, 1 = word, 2 = longword, 3 = any size; the bus size uses the same 0/1/2 encoding.
- R6: Only channel B compares data: a data bit counts only where the mask register (index 7) holds 0; channel A's result does not depend on the data bus.
- R7: With mode bit 0 clear, a valid bus cycle matching either channel drives `brk_req` high for exactly the following clock cycle; non-matching or idle cycles leave it low.
- R8: With mode bit 0 set, a channel A match arms the sequencer without a break; a channel B match raises `brk_req` only while armed, and a firing break disarms it.
- R9: Any register write disarms the sequencer, so a channel B match after the write raises no break.
- R10: `brk_after` rises with `brk_req` only when the firing cycle is an instruction fetch and the firing channel's control bit [9] is set; data breaks report 0.
- R11: `stat_a` and `stat_b` set on every match of their channel and hold until a write to index 9 with bit 0 (A) or bit 1 (B) set; a write with only the other bit set leaves the flag unchanged.
- R12: After reset both channels are off, the data mask is all ones, the mode is independent, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_addr | input | 32 | Logical address of the cycle |
| bus_asid | input | 8 | Address-space ID of the cycle |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Operand size, 0 byte, 1 word, 2 longword |
| bus_data | input | 32 | Data on the bus |
| brk_req | output | 1 | One-cycle break request |
| brk_after | output | 1 | Fetch break to be taken after execution |
| stat_a | output | 1 | Sticky channel A match flag |
| stat_b | output | 1 | Sticky channel B match flag |

## Verification
The bench sweeps each address mask against flips just below and just above bit 10 and bit 12, so a mask that is off by one granule accepts or rejects the wrong neighbour. It runs every combination of cycle kind, direction and size settings against every bus cycle shape, catching a swapped encoding or an "off" kind that still matches. The data sweep flips each bit under several mask patterns, exposing an inverted mask sense. The sequential tests cover B before A, a repeat B after firing, and a register write between A and B; a sequencer that never disarms would fire twice, and one that ignores writes would fire after reprogramming.

// File: rtl/bbu_pkg.sv
package bbu_pkg;

  typedef enum logic [1:0] {
    AM_FULL   = 2'd0,
    AM_FINE   = 2'd1,
    AM_COARSE = 2'd2,
    AM_NONE   = 2'd3
  } amask_e;

  // channel control word, bit 0 at the bottom
  typedef struct packed {
    logic       after;     // [9]
    logic [1:0] size;      // [8:7]
    logic [1:0] dir;       // [6:5]
    logic [1:0] kind;      // [4:3]
    logic       asid_ign;  // [2]
    amask_e     amode;     // [1:0]
  } chan_ctrl_t;

  localparam int CTRL_W = $bits(chan_ctrl_t);

  localparam int IDX_A_ADDR = 0;
  localparam int IDX_A_ASID = 1;
  localparam int IDX_A_CTRL = 2;
  localparam int IDX_B_ADDR = 3;
  localparam int IDX_B_ASID = 4;
  localparam int IDX_B_CTRL = 5;
  localparam int IDX_B_DATA = 6;
  localparam int IDX_B_DMSK = 7;
  localparam int IDX_MODE   = 8;
  localparam int IDX_CLR    = 9;

endpackage

// File: rtl/bbu_regs.sv
module bbu_regs
  import bbu_pkg::*;
#(
  parameter int AW  = 32,
  parameter int IW  = 8,
  parameter int DW  = 32,
  parameter int RIW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_wr,
  input  logic [RIW-1:0] reg_idx,
  input  logic [DW-1:0]  reg_wdata,
  output logic [AW-1:0]  a_addr,
  output logic [IW-1:0]  a_asid,
  output chan_ctrl_t     a_ctrl,
  output logic [AW-1:0]  b_addr,
  output logic [IW-1:0]  b_asid,
  output chan_ctrl_t     b_ctrl,
  output logic [DW-1:0]  b_data,
  output logic [DW-1:0]  b_dmask,
  output logic           seq_mode
);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_addr   <= '0;
      a_asid   <= '0;
      a_ctrl   <= '0;
      b_addr   <= '0;
      b_asid   <= '0;
      b_ctrl   <= '0;
      b_data   <= '0;
      b_dmask  <= '1;
      seq_mode <= 1'b0;
    end else if (reg_wr) begin
      case (reg_idx)
        RIW'(IDX_A_ADDR): a_addr   <= reg_wdata[AW-1:0];
        RIW'(IDX_A_ASID): a_asid   <= reg_wdata[IW-1:0];
        RIW'(IDX_A_CTRL): a_ctrl   <= chan_ctrl_t'(reg_wdata[CTRL_W-1:0]);
        RIW'(IDX_B_ADDR): b_addr   <= reg_wdata[AW-1:0];
        RIW'(IDX_B_ASID): b_asid   <= reg_wdata[IW-1:0];
        RIW'(IDX_B_CTRL): b_ctrl   <= chan_ctrl_t'(reg_wdata[CTRL_W-1:0]);
        RIW'(IDX_B_DATA): b_data   <= reg_wdata;
        RIW'(IDX_B_DMSK): b_dmask  <= reg_wdata;
        RIW'(IDX_MODE):   seq_mode <= reg_wdata[0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/bbu_chan.sv
module bbu_chan
  import bbu_pkg::*;
#(
  parameter int AW         = 32,
  parameter int IW         = 8,
  parameter int DW         = 32,
  parameter int LOW_FINE   = 10,
  parameter int LOW_COARSE = 12,
  parameter bit HAS_DATA   = 1'b0
) (
  input  chan_ctrl_t    ctrl,
  input  logic [AW-1:0] cfg_addr,
  input  logic [IW-1:0] cfg_asid,
  input  logic [DW-1:0] cfg_data,
  input  logic [DW-1:0] cfg_dmask,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic [IW-1:0] bus_asid,
  input  logic          bus_fetch,
  input  logic          bus_write,
  input  logic [1:0]    bus_size,
  input  logic [DW-1:0] bus_data,
  output logic          hit,
  output logic          after
);

  logic [AW-1:0] amask;
  logic addr_ok, asid_ok, kind_ok, dir_ok, size_ok, data_cmp, data_ok;

  always_comb begin
    case (ctrl.amode)
      AM_FULL:   amask = '1;
      AM_FINE:   amask = {AW{1'b1}} << LOW_FINE;
      AM_COARSE: amask = {AW{1'b1}} << LOW_COARSE;
      default:   amask = '0;
    endcase
  end

  assign addr_ok  = ((bus_addr ^ cfg_addr) & amask) == '0;
  assign asid_ok  = ctrl.asid_ign || (bus_asid == cfg_asid);
  assign kind_ok  = (ctrl.kind[0] && bus_fetch) || (ctrl.kind[1] && !bus_fetch);
  assign dir_ok   = (ctrl.dir == 2'b00) || (ctrl.dir == 2'b11) ||
                    (ctrl.dir == 2'b01 && !bus_write) ||
                    (ctrl.dir == 2'b10 && bus_write);
  assign size_ok  = (ctrl.size == 2'b11) || (ctrl.size == bus_size);
  assign data_cmp = ((bus_data ^ cfg_data) & ~cfg_dmask) == '0;
  assign data_ok  = HAS_DATA ? data_cmp : 1'b1;

  assign hit   = bus_valid && addr_ok && asid_ok && kind_ok && dir_ok && size_ok && data_ok;
  assign after = ctrl.after && bus_fetch;

endmodule

// File: rtl/bbu_seq.sv
module bbu_seq (
  input  logic clk,
  input  logic rst,
  input  logic seq_mode,
  input  logic cfg_wr,
  input  logic hit_a,
  input  logic hit_b,
  input  logic aft_a,
  input  logic aft_b,
  input  logic clr_a,
  input  logic clr_b,
  output logic brk_req,
  output logic brk_after,
  output logic stat_a,
  output logic stat_b
);

  logic armed_q;
  logic fire, fire_aft;

  assign fire     = seq_mode ? (hit_b && armed_q) : (hit_a || hit_b);
  assign fire_aft = (seq_mode || !hit_a) ? aft_b : aft_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q   <= 1'b0;
      brk_req   <= 1'b0;
      brk_after <= 1'b0;
      stat_a    <= 1'b0;
      stat_b    <= 1'b0;
    end else begin
      brk_req   <= fire;
      brk_after <= fire && fire_aft;
      if (cfg_wr || fire)
        armed_q <= 1'b0;
      else if (seq_mode && hit_a)
        armed_q <= 1'b1;
      stat_a <= hit_a || (stat_a && !clr_a);
      stat_b <= hit_b || (stat_b && !clr_b);
    end
  end

endmodule

// File: rtl/bus_break_unit.sv
module bus_break_unit
  import bbu_pkg::*;
#(
  parameter int AW         = 32,
  parameter int IW         = 8,
  parameter int DW         = 32,
  parameter int RIW        = 4,
  parameter int LOW_FINE   = 10,
  parameter int LOW_COARSE = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_wr,
  input  logic [RIW-1:0] reg_idx,
  input  logic [DW-1:0]  reg_wdata,
  input  logic           bus_valid,
  input  logic [AW-1:0]  bus_addr,
  input  logic [IW-1:0]  bus_asid,
  input  logic           bus_fetch,
  input  logic           bus_write,
  input  logic [1:0]     bus_size,
  input  logic [DW-1:0]  bus_data,
  output logic           brk_req,
  output logic           brk_after,
  output logic           stat_a,
  output logic           stat_b
);

  logic [AW-1:0] a_addr, b_addr;
  logic [IW-1:0] a_asid, b_asid;
  chan_ctrl_t    a_ctrl, b_ctrl;
  logic [DW-1:0] b_data, b_dmask;
  logic          seq_mode;
  logic          hit_a, hit_b, aft_a, aft_b;
  logic          clr_a, clr_b;

  assign clr_a = reg_wr && (reg_idx == RIW'(IDX_CLR)) && reg_wdata[0];
  assign clr_b = reg_wr && (reg_idx == RIW'(IDX_CLR)) && reg_wdata[1];

  bbu_regs #(.AW(AW), .IW(IW), .DW(DW), .RIW(RIW)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .a_addr(a_addr), .a_asid(a_asid), .a_ctrl(a_ctrl),
    .b_addr(b_addr), .b_asid(b_asid), .b_ctrl(b_ctrl),
    .b_data(b_data), .b_dmask(b_dmask), .seq_mode(seq_mode)
  );

  bbu_chan #(.AW(AW), .IW(IW), .DW(DW), .LOW_FINE(LOW_FINE),
             .LOW_COARSE(LOW_COARSE), .HAS_DATA(1'b0)) u_chan_a (
    .ctrl(a_ctrl), .cfg_addr(a_addr), .cfg_asid(a_asid),
    .cfg_data('0), .cfg_dmask('1),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_asid(bus_asid),
    .bus_fetch(bus_fetch), .bus_write(bus_write), .bus_size(bus_size),
    .bus_data(bus_data), .hit(hit_a), .after(aft_a)
  );

  bbu_chan #(.AW(AW), .IW(IW), .DW(DW), .LOW_FINE(LOW_FINE),
             .LOW_COARSE(LOW_COARSE), .HAS_DATA(1'b1)) u_chan_b (
    .ctrl(b_ctrl), .cfg_addr(b_addr), .cfg_asid(b_asid),
    .cfg_data(b_data), .cfg_dmask(b_dmask),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_asid(bus_asid),
    .bus_fetch(bus_fetch), .bus_write(bus_write), .bus_size(bus_size),
    .bus_data(bus_data), .hit(hit_b), .after(aft_b)
  );

  bbu_seq u_seq (
    .clk(clk), .rst(rst), .seq_mode(seq_mode), .cfg_wr(reg_wr),
    .hit_a(hit_a), .hit_b(hit_b), .aft_a(aft_a), .aft_b(aft_b),
    .clr_a(clr_a), .clr_b(clr_b),
    .brk_req(brk_req), .brk_after(brk_after), .stat_a(stat_a), .stat_b(stat_b)
  );

endmodule

// File: rtl/bbu_chk.sv
module bbu_chk (
  input logic clk,
  input logic rst,
  input logic bus_valid,
  input logic bus_fetch,
  input logic clr_a,
  input logic clr_b,
  input logic brk_req,
  input logic brk_after,
  input logic stat_a,
  input logic stat_b
);

  // R7
  idle_no_break_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |=> !brk_req);

  // R10
  data_no_after_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_fetch) |=> !brk_after);

  // R10
  after_with_req_chk: assert property (@(posedge clk) disable iff (rst)
    brk_after |-> brk_req);

  // R11
  req_marks_status_chk: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> (stat_a || stat_b));

  // R11
  stat_a_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_a && !clr_a) |=> stat_a);

  // R11
  stat_b_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_b && !clr_b) |=> stat_b);

endmodule

bind bus_break_unit bbu_chk u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_fetch(bus_fetch),
  .clr_a(clr_a), .clr_b(clr_b), .brk_req(brk_req), .brk_after(brk_after),
  .stat_a(stat_a), .stat_b(stat_b)
);

// File: tb/bus_break_unit_test.sv
module bus_break_unit_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr;
  logic [3:0]  reg_idx;
  logic [31:0] reg_wdata;
  logic        bus_valid;
  logic [31:0] bus_addr;
  logic [7:0]  bus_asid;
  logic        bus_fetch, bus_write;
  logic [1:0]  bus_size;
  logic [31:0] bus_data;
  logic        brk_req, brk_after, stat_a, stat_b;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  bus_break_unit uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_asid(bus_asid),
    .bus_fetch(bus_fetch), .bus_write(bus_write), .bus_size(bus_size),
    .bus_data(bus_data), .brk_req(brk_req), .brk_after(brk_after),
    .stat_a(stat_a), .stat_b(stat_b)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wreg(int idx, logic [31:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = idx[3:0]; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus(logic f, logic w, logic [1:0] sz, logic [31:0] a,
                     logic [7:0] id, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_fetch = f; bus_write = w; bus_size = sz;
    bus_addr = a; bus_asid = id; bus_data = d;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  function automatic logic [31:0] mk(int am, int ai, int k, int d, int s, int af);
    return {22'd0, af[0], s[1:0], d[1:0], k[1:0], ai[0], am[1:0]};
  endfunction

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] dl [7];
    logic [31:0] msk [5];
    dl  = '{32'h0, 32'h1, 32'h200, 32'h400, 32'h800, 32'h1000, 32'h8000_0000};
    msk = '{32'h0, 32'hFFFF_0000, 32'h0000_FFFF, 32'hFFFF_FFFF, 32'h00FF_00FF};
    rst = 1'b1; reg_wr = 1'b0; reg_idx = '0; reg_wdata = '0;
    bus_valid = 1'b0; bus_addr = '0; bus_asid = '0; bus_fetch = 1'b0;
    bus_write = 1'b0; bus_size = '0; bus_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R12 reset state and channels off
    check("R12 brk_req", brk_req, 0);
    check("R12 brk_after", brk_after, 0);
    check("R12 stat", {stat_a, stat_b}, 0);
    bus(1'b1, 1'b0, 2'd2, 32'h0, 8'h0, 32'h0);
    check("R12 default channels off", brk_req, 0);

    // R1 address mask sweep on channel A
    wreg(0, 32'hA5A5_A000);
    for (int m = 0; m < 4; m++) begin
      wreg(2, mk(m, 1, 3, 0, 3, 0));
      for (int j = 0; j < 7; j++) begin
        logic e;
        case (m)
          0: e = (dl[j] == 0);
          1: e = (dl[j] < 32'h400);
          2: e = (dl[j] < 32'h1000);
          default: e = 1'b1;
        endcase
        bus(1'b0, 1'b0, 2'd0, 32'hA5A5_A000 ^ dl[j], 8'h77, 32'h0);
        check("R1 address mask", brk_req, e);
      end
    end

    // R2 ASID full compare vs ignored
    wreg(1, 32'h3C);
    for (int ai = 0; ai < 2; ai++) begin
      wreg(2, mk(3, ai, 3, 0, 3, 0));
      for (int id = 0; id < 256; id++) begin
        bus(1'b1, 1'b0, 2'd2, 32'h1234, id[7:0], 32'h0);
        check("R2 asid", brk_req, (ai == 1) || (id == 32'h3C));
      end
    end

    // R3 R4 R5 cycle kind, direction, size exhaustive; R6 channel A ignores data
    for (int k = 0; k < 4; k++)
      for (int d = 0; d < 4; d++)
        for (int s = 0; s < 4; s++) begin
          wreg(2, mk(0, 1, k, d, s, 0));
          for (int f = 0; f < 2; f++)
            for (int w = 0; w < 2; w++)
              for (int bz = 0; bz < 3; bz++) begin
                logic kok, dok, sok;
                kok = (k == 3) || (k == 1 && f == 1) || (k == 2 && f == 0);
                dok = (d == 0) || (d == 3) || (d == 1 && w == 0) || (d == 2 && w == 1);
                sok = (s == 3) || (s == bz);
                bus(f[0], w[0], bz[1:0], 32'hA5A5_A000, 8'h0, 32'h1357_9BDF * (k + 1));
                check("R3 R4 R5 conditions", brk_req, kok && dok && sok);
              end
        end

    // R6 channel B data compare with per-bit mask
    wreg(2, mk(0, 0, 0, 0, 0, 0));
    wreg(5, mk(3, 1, 3, 0, 3, 0));
    wreg(6, 32'hDEAD_BEEF);
    for (int mi = 0; mi < 5; mi++) begin
      wreg(7, msk[mi]);
      for (int j = 0; j < 32; j++) begin
        logic [31:0] fl;
        fl = 32'h1 << j;
        bus(1'b0, 1'b1, 2'd2, 32'h0, 8'h0, 32'hDEAD_BEEF ^ fl);
        check("R6 data mask", brk_req, (fl & ~msk[mi]) == 0);
      end
      bus(1'b0, 1'b1, 2'd2, 32'h0, 8'h0, 32'hDEAD_BEEF);
      check("R6 data exact", brk_req, 1);
    end

    // R7 independent mode, one-cycle pulse
    wreg(0, 32'h1000_0000); wreg(2, mk(0, 1, 3, 0, 3, 0));
    wreg(3, 32'h2000_0000); wreg(5, mk(0, 1, 3, 0, 3, 0));
    wreg(7, 32'hFFFF_FFFF);
    bus(1'b0, 1'b0, 2'd1, 32'h1000_0000, 8'h0, 32'h5555);
    check("R7 channel A break", brk_req, 1);
    @(negedge clk);
    check("R7 pulse width", brk_req, 0);
    bus(1'b0, 1'b1, 2'd1, 32'h2000_0000, 8'h0, 32'h5555);
    check("R7 channel B break", brk_req, 1);
    bus(1'b0, 1'b1, 2'd1, 32'h3000_0000, 8'h0, 32'h5555);
    check("R7 no match", brk_req, 0);

    // R8 sequential mode
    wreg(8, 1);
    bus(1'b0, 1'b0, 2'd2, 32'h2000_0000, 8'h0, 32'h0);
    check("R8 B before A", brk_req, 0);
    bus(1'b0, 1'b0, 2'd2, 32'h1000_0000, 8'h0, 32'h0);
    check("R8 A arms only", brk_req, 0);
    bus(1'b0, 1'b0, 2'd2, 32'h2000_0000, 8'h0, 32'h0);
    check("R8 B after A", brk_req, 1);
    bus(1'b0, 1'b0, 2'd2, 32'h2000_0000, 8'h0, 32'h0);
    check("R8 disarmed after fire", brk_req, 0);

    // R9 register write disarms
    bus(1'b0, 1'b0, 2'd2, 32'h1000_0000, 8'h0, 32'h0);
    check("R9 A arms", brk_req, 0);
    wreg(0, 32'h1000_0000);
    bus(1'b0, 1'b0, 2'd2, 32'h2000_0000, 8'h0, 32'h0);
    check("R9 write disarmed", brk_req, 0);

    // R10 before/after execution flag
    wreg(8, 0);
    wreg(2, mk(0, 1, 3, 0, 3, 1));
    bus(1'b1, 1'b0, 2'd2, 32'h1000_0000, 8'h0, 32'h0);
    check("R10 fetch after", {brk_req, brk_after}, 2'b11);
    bus(1'b0, 1'b0, 2'd2, 32'h1000_0000, 8'h0, 32'h0);
    check("R10 data no after", {brk_req, brk_after}, 2'b10);
    wreg(2, mk(0, 1, 3, 0, 3, 0));
    bus(1'b1, 1'b0, 2'd2, 32'h1000_0000, 8'h0, 32'h0);
    check("R10 fetch before", {brk_req, brk_after}, 2'b10);

    // R11 sticky status with write-to-clear
    wreg(9, 3);
    check("R11 cleared", {stat_a, stat_b}, 2'b00);
    bus(1'b0, 1'b0, 2'd2, 32'h1000_0000, 8'h0, 32'h0);
    check("R11 A set", {stat_a, stat_b}, 2'b10);
    repeat (3) @(negedge clk);
    check("R11 A held", {stat_a, stat_b}, 2'b10);
    wreg(9, 2);
    check("R11 other clear bit", stat_a, 1);
    wreg(9, 1);
    check("R11 A clear", stat_a, 0);
    bus(1'b0, 1'b0, 2'd2, 32'h2000_0000, 8'h0, 32'h0);
    check("R11 B set", {stat_a, stat_b}, 2'b01);
    wreg(9, 2);
    check("R11 B clear", stat_b, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule